// File: doc/BRIEF.md
# Virtual JTAG Hub Discovery Master

This block is a JTAG host that owns the TCK, TMS and TDI pins and reads TDO from an attached device. That device carries a virtual JTAG hub: a second instruction layer behind the two user instructions of the physical TAP. The hub exposes a configuration word. From that word the master learns how many nodes hang on the hub and how wide the virtual instruction is. It then reads one info word per node, finds the node whose identifier is 0x08, and writes the debug command into that node's virtual IR. It finishes with the data path to that node selected, so that a later transfer engine can use it.

A single `start` pulse runs the whole sequence with no further input. When it ends, `done` pulses for one cycle. `error` reports whether discovery failed, and three outputs give the node address, the command-field width m and the address-field width n. The TCK rate comes from a divider value sampled at run time.

Top module: `vhub_enum_master`

## Requirements
- R1: After `start`, the master first drives at least five TMS ones with TCK running and then a zero, so the target TAP reaches test-logic-reset from any state and ends in run-test-idle.
- R2: The physical IR is loaded, IR_LEN bits LSB first, exactly four times in a successful run, in the order 0x0E, 0x0C, 0x0E, 0x0C. Each scan returns the TAP to run-test-idle.
- R3: The first DR scan after the first 0x0E load is 64 bits long and all its TDI bits are zero.
- R4: The hub word is read as eight separate 4-bit DR scans, each passing through update-DR. The first nibble read becomes bits 3:0 and the last becomes bits 31:28. The node count is taken from bits 26:19 and m from bits 7:0, and m is reported on `m_width`.
- R5: Each node is read with eight further nibble scans. The address reported on `node_addr` is the node's position plus one (first node = 1) for the last node whose bits 26:19 equal 0x08.
- R6: `n_width` is the position of the highest set bit of the node count, counted from 1. The scan after the second 0x0E load is a DR scan of n+m bits carrying (address shifted left by m) OR 0x8, LSB first.
- R7: If no node matches, including the case of zero nodes, the master raises `error` and pulses `done` with `node_addr` = 0. It issues no further scans after the last node read.
- R8: If n+m exceeds 64, the master raises `error` without loading the IR again. A sum of exactly 64 is accepted.
- R9: TCK stays high and stays low for `clk_div`+1 system clocks each. It is held low whenever no scan is running.
- R10: TMS and TDI change only while TCK is low. TDO is taken at the system clock where TCK rises.
- R11: After reset, `done`, `error`, `tck` and `node_addr` are 0. `done` is high for one cycle per run. `error` holds until the next `start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a discovery run (taken when idle) |
| clk_div | input | DIV_W | TCK half-period in system clocks, minus one |
| tdo | input | 1 | Test data from the device |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the device |
| done | output | 1 | One-cycle pulse at the end of a run |
| error | output | 1 | Run failed (no node, or field too wide) |
| node_addr | output | 8 | Hub address of the selected node |
| m_width | output | 8 | Virtual command field width |
| n_width | output | 4 | Virtual address field width |

## Verification
The bench builds the master with its default parameters: a 10-bit physical IR, a 64-bit scan limit and an 8-bit divider. The hub, the node count and m are all supplied at run time by the bench's device model, so no rebuild is needed to cover every case. Hub words with m of 61 and 62 beside four nodes put the 64-bit limit exactly at and just past its edge. Divider values 0, 1 and 3 exercise the TCK timing. Node lists with no match, zero nodes, a single node and a duplicated identifier reach the failure path and the last-match rule.

// File: rtl/vhub_pkg.sv
// Shared types and helpers for the virtual hub discovery master.
// Assumes node counts and widths fit in eight bits.
package vhub_pkg;

    typedef enum logic [1:0] {
        SK_RESET = 2'd0,
        SK_IR    = 2'd1,
        SK_DR    = 2'd2
    } scan_kind_e;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_RESET, SQ_U1_A, SQ_FLUSH, SQ_U0_A,
        SQ_HUB, SQ_NODE, SQ_CHECK, SQ_U1_B, SQ_VIR, SQ_U0_B
    } seq_state_e;

    // Position of the highest set bit, counted from 1; zero for zero.
    function automatic logic [3:0] bit_len8(input logic [7:0] v);
        logic [3:0] r;
        r = 4'd0;
        for (int i = 0; i < 8; i++) begin
            if (v[i]) r = 4'(i + 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/vhub_tck_gen.sv
// Test clock generator. While en is high, TCK toggles every div+1 system
// clocks, starting low. rise/fall flag the system clock at which TCK changes.
// Assumes en drops only at a fall tick, so TCK is never cut short while high.
module vhub_tck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tck,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = en && (cnt_q >= div);
    assign rise = wrap && !tck;
    assign fall = wrap && tck;

    // Count system clocks per half period and toggle TCK at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            tck   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            tck   <= ~tck;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r9_tck_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tck) |-> $past(en));

endmodule

// File: rtl/vhub_scan_engine.sv
// Runs one JTAG operation from run-test-idle back to run-test-idle: a TAP
// reset, an IR scan or a DR scan of len bits, TDI LSB first. TMS/TDI are
// updated at fall ticks; TDO is captured at rise ticks of shift states, and
// the last four captured bits are presented on rx_nib (first bit lowest).
module vhub_scan_engine
    import vhub_pkg::*;
#(
    parameter int MAX_SCAN = 64,
    parameter int LEN_W    = $clog2(MAX_SCAN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  scan_kind_e          kind,
    input  logic [LEN_W-1:0]    len,
    input  logic [MAX_SCAN-1:0] data,
    input  logic                rise,
    input  logic                fall,
    input  logic                tdo,
    output logic                busy,
    output logic                done,
    output logic                tms,
    output logic                tdi,
    output logic [3:0]          rx_nib
);
    localparam int STEP_W = $clog2(MAX_SCAN + 8);
    localparam int IDX_W  = $clog2(MAX_SCAN);

    scan_kind_e          kind_q;
    logic [LEN_W-1:0]    len_q;
    logic [MAX_SCAN-1:0] data_q;
    logic [STEP_W-1:0]   step_q, pre_c, end_c, last_c, off_c;
    logic                fin_q, in_shift, tms_c, tdi_c;

    // Derive the step layout of the current operation and the pin values.
    always_comb begin
        pre_c    = (kind_q == SK_IR) ? STEP_W'(4) : STEP_W'(3);
        end_c    = pre_c + STEP_W'(len_q);
        last_c   = (kind_q == SK_RESET) ? STEP_W'(5) : end_c + STEP_W'(1);
        in_shift = (kind_q != SK_RESET) && (step_q >= pre_c) && (step_q < end_c);
        off_c    = step_q - pre_c;
        if (kind_q == SK_RESET)
            tms_c = step_q < STEP_W'(5);
        else if (step_q < pre_c)
            tms_c = (kind_q == SK_IR) ? (step_q < STEP_W'(2)) : (step_q == '0);
        else if (step_q < end_c)
            tms_c = step_q == end_c - STEP_W'(1);
        else
            tms_c = step_q == end_c;
        tdi_c = in_shift ? data_q[off_c[IDX_W-1:0]] : 1'b0;
    end

    // Step through the operation: launch pins at falls, capture at rises.
    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (!rst_n) begin
            busy   <= 1'b0;
            fin_q  <= 1'b0;
            step_q <= '0;
            kind_q <= SK_RESET;
            len_q  <= '0;
            data_q <= '0;
            tms    <= 1'b1;
            tdi    <= 1'b0;
            rx_nib <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            fin_q  <= 1'b0;
            step_q <= '0;
            kind_q <= kind;
            len_q  <= len;
            data_q <= data;
            tms    <= 1'b1;
            tdi    <= 1'b0;
        end else if (busy) begin
            if (rise) begin
                if (in_shift) rx_nib <= {tdo, rx_nib[3:1]};
                if (step_q == last_c) fin_q <= 1'b1;
                else                  step_q <= step_q + STEP_W'(1);
            end
            if (fall) begin
                if (fin_q) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    tms <= tms_c;
                    tdi <= tdi_c;
                end
            end
        end
    end

    a_r2_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

endmodule

// File: rtl/vhub_enum_seq.sv
// Discovery sequencer. Issues the ordered list of operations to the scan
// engine, assembles hub and node words from nibble reads, picks the target
// node and forms the address-plus-command virtual IR write.
// Assumes the engine accepts eng_start one cycle after each eng_done.
module vhub_enum_seq
    import vhub_pkg::*;
#(
    parameter int          IR_LEN    = 10,
    parameter int          MAX_SCAN  = 64,
    parameter int          LEN_W     = $clog2(MAX_SCAN + 1),
    parameter int unsigned USER1_OP  = 'h0E,
    parameter int unsigned USER0_OP  = 'h0C,
    parameter int unsigned TARGET_ID = 'h08,
    parameter int unsigned DBG_CMD   = 'h8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                eng_busy,
    input  logic                eng_done,
    input  logic [3:0]          eng_nib,
    output logic                eng_start,
    output scan_kind_e          eng_kind,
    output logic [LEN_W-1:0]    eng_len,
    output logic [MAX_SCAN-1:0] eng_data,
    output logic                done,
    output logic                error,
    output logic [7:0]          node_addr,
    output logic [7:0]          m_width,
    output logic [3:0]          n_width
);
    localparam int NIB_BITS = 4;

    seq_state_e    state_q;
    logic          go_q, found_q;
    logic [2:0]    nib_q;
    logic [7:0]    idx_q, cnt_q;
    logic [31:0]   acc_q, acc_nx;
    logic [8:0]    vir_len;
    logic          too_wide;

    assign acc_nx    = {eng_nib, acc_q[31:4]};
    assign vir_len   = 9'(n_width) + 9'(m_width);
    assign too_wide  = vir_len > 9'(MAX_SCAN);
    assign eng_start = go_q;

    // Select the operation that belongs to the current step.
    always_comb begin
        eng_kind = SK_DR;
        eng_len  = LEN_W'(NIB_BITS);
        eng_data = '0;
        case (state_q)
            SQ_RESET: eng_kind = SK_RESET;
            SQ_U1_A, SQ_U1_B: begin
                eng_kind = SK_IR;
                eng_len  = LEN_W'(IR_LEN);
                eng_data = MAX_SCAN'(USER1_OP);
            end
            SQ_U0_A, SQ_U0_B: begin
                eng_kind = SK_IR;
                eng_len  = LEN_W'(IR_LEN);
                eng_data = MAX_SCAN'(USER0_OP);
            end
            SQ_FLUSH: eng_len = LEN_W'(MAX_SCAN);
            SQ_VIR: begin
                eng_len  = LEN_W'(vir_len);
                eng_data = (MAX_SCAN'(node_addr) << m_width) | MAX_SCAN'(DBG_CMD);
            end
            default: ;
        endcase
    end

    // Advance through the discovery steps on each completed operation.
    always_ff @(posedge clk) begin
        done <= 1'b0;
        go_q <= 1'b0;
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            found_q   <= 1'b0;
            nib_q     <= '0;
            idx_q     <= '0;
            cnt_q     <= '0;
            acc_q     <= '0;
            error     <= 1'b0;
            node_addr <= '0;
            m_width   <= '0;
            n_width   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (start) begin
                    error     <= 1'b0;
                    found_q   <= 1'b0;
                    node_addr <= '0;
                    m_width   <= '0;
                    n_width   <= '0;
                    nib_q     <= '0;
                    state_q   <= SQ_RESET;
                    go_q      <= 1'b1;
                end
                SQ_RESET: if (eng_done) begin state_q <= SQ_U1_A;  go_q <= 1'b1; end
                SQ_U1_A:  if (eng_done) begin state_q <= SQ_FLUSH; go_q <= 1'b1; end
                SQ_FLUSH: if (eng_done) begin state_q <= SQ_U0_A;  go_q <= 1'b1; end
                SQ_U0_A:  if (eng_done) begin state_q <= SQ_HUB;   go_q <= 1'b1; end
                SQ_HUB: if (eng_done) begin
                    acc_q <= acc_nx;
                    nib_q <= nib_q + 3'd1;
                    go_q  <= 1'b1;
                    if (nib_q == 3'd7) begin
                        cnt_q   <= acc_nx[26:19];
                        m_width <= acc_nx[7:0];
                        n_width <= bit_len8(acc_nx[26:19]);
                        idx_q   <= '0;
                        if (acc_nx[26:19] == 8'd0) begin
                            state_q <= SQ_CHECK;
                            go_q    <= 1'b0;
                        end else begin
                            state_q <= SQ_NODE;
                        end
                    end
                end
                SQ_NODE: if (eng_done) begin
                    acc_q <= acc_nx;
                    nib_q <= nib_q + 3'd1;
                    go_q  <= 1'b1;
                    if (nib_q == 3'd7) begin
                        if (acc_nx[26:19] == 8'(TARGET_ID)) begin
                            found_q   <= 1'b1;
                            node_addr <= idx_q + 8'd1;
                        end
                        if (idx_q == cnt_q - 8'd1) begin
                            state_q <= SQ_CHECK;
                            go_q    <= 1'b0;
                        end else begin
                            idx_q <= idx_q + 8'd1;
                        end
                    end
                end
                SQ_CHECK: begin
                    if (!found_q || too_wide) begin
                        error   <= 1'b1;
                        done    <= 1'b1;
                        state_q <= SQ_IDLE;
                    end else begin
                        state_q <= SQ_U1_B;
                        go_q    <= 1'b1;
                    end
                end
                SQ_U1_B: if (eng_done) begin state_q <= SQ_VIR;  go_q <= 1'b1; end
                SQ_VIR:  if (eng_done) begin state_q <= SQ_U0_B; go_q <= 1'b1; end
                SQ_U0_B: if (eng_done) begin
                    done    <= 1'b1;
                    state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> done);
    a_r5_addr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error) |-> (node_addr != 8'd0));
    a_r7_no_scan_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (done && error) |-> !eng_busy);

endmodule

// File: rtl/vhub_enum_master.sv
// Top of the virtual hub discovery master: test clock generator, single
// operation scan engine and discovery sequencer. Assumes IR_LEN <= MAX_SCAN
// and MAX_SCAN >= 64 so the hub flush fits in one scan.
module vhub_enum_master
    import vhub_pkg::*;
#(
    parameter int IR_LEN   = 10,
    parameter int MAX_SCAN = 64,
    parameter int DIV_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             tdo,
    output logic             tck,
    output logic             tms,
    output logic             tdi,
    output logic             done,
    output logic             error,
    output logic [7:0]       node_addr,
    output logic [7:0]       m_width,
    output logic [3:0]       n_width
);
    localparam int LEN_W = $clog2(MAX_SCAN + 1);

    logic                eng_busy, eng_done, eng_start, tck_rise, tck_fall;
    logic [3:0]          eng_nib;
    scan_kind_e          eng_kind;
    logic [LEN_W-1:0]    eng_len;
    logic [MAX_SCAN-1:0] eng_data;

    vhub_tck_gen #(.DIV_W(DIV_W)) u_tck (
        .clk(clk), .rst_n(rst_n), .en(eng_busy), .div(clk_div),
        .tck(tck), .rise(tck_rise), .fall(tck_fall)
    );

    vhub_scan_engine #(.MAX_SCAN(MAX_SCAN), .LEN_W(LEN_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .kind(eng_kind),
        .len(eng_len), .data(eng_data), .rise(tck_rise), .fall(tck_fall),
        .tdo(tdo), .busy(eng_busy), .done(eng_done), .tms(tms), .tdi(tdi),
        .rx_nib(eng_nib)
    );

    vhub_enum_seq #(.IR_LEN(IR_LEN), .MAX_SCAN(MAX_SCAN), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .eng_busy(eng_busy),
        .eng_done(eng_done), .eng_nib(eng_nib), .eng_start(eng_start),
        .eng_kind(eng_kind), .eng_len(eng_len), .eng_data(eng_data),
        .done(done), .error(error), .node_addr(node_addr),
        .m_width(m_width), .n_width(n_width)
    );

    a_r10_tms_tck_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tms) |-> !tck);
    a_r10_tdi_tck_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tdi) |-> !tck);
    a_r9_tck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |=> !tck);

endmodule

// File: tb/vhub_enum_master_tb.sv
// Directed bench: a behavioural TAP with a virtual hub answers the master.
module vhub_enum_master_tb;
    localparam int IR_LEN = 10;
    localparam logic [IR_LEN-1:0] OP_U1 = 10'h00E;
    localparam logic [IR_LEN-1:0] OP_U0 = 10'h00C;
    localparam logic [3:0] S_TLR=0, S_RTI=1, S_SELDR=2, S_CAPDR=3, S_SHDR=4,
        S_EX1DR=5, S_PADR=6, S_EX2DR=7, S_UPDR=8, S_SELIR=9, S_CAPIR=10,
        S_SHIR=11, S_EX1IR=12, S_PAIR=13, S_EX2IR=14, S_UPIR=15;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tdo, mdl_clr = 1'b0;
    logic [7:0] clk_div = 8'd3;
    logic tck, tms, tdi, done, error;
    logic [7:0] node_addr, m_width;
    logic [3:0] n_width;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    vhub_enum_master u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .clk_div(clk_div), .tdo(tdo),
        .tck(tck), .tms(tms), .tdi(tdi), .done(done), .error(error),
        .node_addr(node_addr), .m_width(m_width), .n_width(n_width)
    );

    // ---------------- device model ----------------
    logic [31:0] words [0:7];
    logic [3:0]  st;
    logic [IR_LEN-1:0] ir_sr, ir_q;
    logic [IR_LEN-1:0] ir_log [0:7];
    logic [3:0]  ir_n;
    logic [63:0] dr_sr, vir_first, vir_last;
    int dr_cnt, vir_first_cnt, vir_last_cnt, vir_n, p, nib_total;
    logic [3:0] nib_sr;
    logic tlr_seen;

    function automatic logic [3:0] nxt(input logic [3:0] s, input logic m);
        case (s)
            S_TLR: return m ? S_TLR : S_RTI;
            S_RTI: return m ? S_SELDR : S_RTI;
            S_SELDR: return m ? S_SELIR : S_CAPDR;
            S_CAPDR, S_SHDR: return m ? S_EX1DR : S_SHDR;
            S_EX1DR: return m ? S_UPDR : S_PADR;
            S_PADR: return m ? S_EX2DR : S_PADR;
            S_EX2DR: return m ? S_UPDR : S_SHDR;
            S_SELIR: return m ? S_TLR : S_CAPIR;
            S_CAPIR, S_SHIR: return m ? S_EX1IR : S_SHIR;
            S_EX1IR: return m ? S_UPIR : S_PAIR;
            S_PAIR: return m ? S_EX2IR : S_PAIR;
            S_EX2IR: return m ? S_UPIR : S_SHIR;
            default: return m ? S_SELDR : S_RTI;
        endcase
    endfunction

    function automatic logic [3:0] nib_at(input int q);
        logic [31:0] w;
        w = words[q / 8] >> (4 * (q % 8));
        return w[3:0];
    endfunction

    always @(posedge tck or posedge mdl_clr) begin
        if (mdl_clr) begin
            st <= S_PADR; ir_n <= '0; vir_n <= 0; p <= 0; nib_total <= 0;
            tlr_seen <= 1'b0; dr_cnt <= 0; ir_q <= '0; ir_sr <= '0;
            dr_sr <= '0; nib_sr <= '0; vir_first <= '0; vir_last <= '0;
            vir_first_cnt <= 0; vir_last_cnt <= 0;
        end else begin
            case (st)
                S_TLR: begin tlr_seen <= 1'b1; ir_q <= '0; end
                S_CAPIR: ir_sr <= IR_LEN'(1);
                S_SHIR: ir_sr <= {tdi, ir_sr[IR_LEN-1:1]};
                S_UPIR: begin ir_q <= ir_sr; ir_log[ir_n[2:0]] <= ir_sr; ir_n <= ir_n + 4'd1; end
                S_CAPDR: begin dr_cnt <= 0; nib_sr <= nib_at(p); end
                S_SHDR: begin
                    dr_sr <= {tdi, dr_sr[63:1]}; dr_cnt <= dr_cnt + 1;
                    nib_sr <= {1'b0, nib_sr[3:1]};
                end
                S_UPDR: begin
                    if (ir_q == OP_U1) begin
                        vir_last <= dr_sr >> (64 - dr_cnt); vir_last_cnt <= dr_cnt;
                        if (vir_n == 0) begin
                            vir_first <= dr_sr >> (64 - dr_cnt); vir_first_cnt <= dr_cnt;
                        end
                        vir_n <= vir_n + 1; p <= 0;
                    end else if (ir_q == OP_U0) begin
                        p <= p + 1; nib_total <= nib_total + 1;
                    end
                end
                default: ;
            endcase
            st <= nxt(st, tms);
        end
    end

    always @(negedge tck or posedge mdl_clr) begin
        if (mdl_clr) tdo <= 1'b0;
        else tdo <= (st == S_SHDR && ir_q == OP_U0) ? nib_sr[0] : 1'b0;
    end

    // ---------------- pin monitors ----------------
    logic p_tck = 1'b0, p_tms = 1'b1, p_tdi = 1'b0;
    int viol = 0, hi_run = 0, last_hi = 0;
    always @(negedge clk) begin
        if (tck && p_tck && (tms !== p_tms || tdi !== p_tdi)) viol <= viol + 1;
        if (tck) hi_run <= hi_run + 1;
        else if (hi_run != 0) begin last_hi <= hi_run; hi_run <= 0; end
        p_tck <= tck; p_tms <= tms; p_tdi <= tdi;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] hub_w(input logic [7:0] cnt, input logic [7:0] m);
        return {5'd1, cnt, 11'h06E, m};
    endfunction

    function automatic logic [31:0] node_w(input logic [7:0] id);
        return {5'd1, id, 11'h06E, 8'd0};
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    logic run_err;
    task automatic run(input logic [7:0] div);
        bit seen;
        seen = 1'b0;
        clk_div = div;
        mdl_clr = 1'b1; #1; mdl_clr = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; break; end
        end
        if (!seen) begin
            n_chk++; n_fail++;
            $display("FAIL R11 watchdog: actual no done expected done");
            finish_run();
        end
        run_err = error;
        @(negedge clk);
        chk("R11", "done single cycle", done, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        chk("R11", "done after reset", done, 0);
        chk("R11", "error after reset", error, 0);
        chk("R11", "addr after reset", node_addr, 0);
        chk("R9", "tck low after reset", tck, 0);
    endtask

    task automatic t_basic();
        words[0] = hub_w(8'd3, 8'd4);
        words[1] = node_w(8'h04); words[2] = node_w(8'h08); words[3] = node_w(8'h84);
        run(8'd3);
        chk("R1", "reset reached", tlr_seen, 1);
        chk("R2", "ends in idle", st, S_RTI);
        chk("R2", "ir load count", ir_n, 4);
        chk("R2", "ir 1st", ir_log[0], OP_U1);
        chk("R2", "ir 2nd", ir_log[1], OP_U0);
        chk("R2", "ir 3rd", ir_log[2], OP_U1);
        chk("R2", "ir 4th", ir_log[3], OP_U0);
        chk("R3", "flush length", vir_first_cnt, 64);
        chk("R3", "flush value", vir_first, 0);
        chk("R4", "nibble scans", nib_total, 32);
        chk("R4", "m", m_width, 4);
        chk("R5", "error", run_err, 0);
        chk("R5", "address", node_addr, 2);
        chk("R6", "n", n_width, 2);
        chk("R6", "vir length", vir_last_cnt, 6);
        chk("R6", "vir value", vir_last, 64'h28);
        chk("R9", "tck high width", last_hi, 4);
        chk("R10", "pin changes while tck high", viol, 0);
    endtask

    task automatic t_no_match();
        words[0] = hub_w(8'd2, 8'd4);
        words[1] = node_w(8'h00); words[2] = node_w(8'h04);
        run(8'd0);
        chk("R7", "error", run_err, 1);
        chk("R7", "address", node_addr, 0);
        chk("R7", "no later ir load", ir_n, 2);
        chk("R7", "no vir write", vir_n, 1);
        repeat (20) @(negedge clk);
        chk("R11", "error held", error, 1);
        chk("R9", "tck idle low", tck, 0);
    endtask

    task automatic t_zero_nodes();
        words[0] = hub_w(8'd0, 8'd4);
        run(8'd1);
        chk("R7", "zero nodes error", run_err, 1);
        chk("R7", "only hub read", nib_total, 8);
    endtask

    task automatic t_single();
        words[0] = hub_w(8'd1, 8'd8);
        words[1] = node_w(8'h08);
        run(8'd1);
        chk("R11", "error cleared by start", run_err, 0);
        chk("R5", "address", node_addr, 1);
        chk("R6", "n", n_width, 1);
        chk("R6", "vir length", vir_last_cnt, 9);
        chk("R6", "vir value", vir_last, 64'h108);
        chk("R9", "tck high width", last_hi, 2);
    endtask

    task automatic t_duplicate();
        words[0] = hub_w(8'd4, 8'd5);
        words[1] = node_w(8'h08); words[2] = node_w(8'h04);
        words[3] = node_w(8'h08); words[4] = node_w(8'h00);
        run(8'd0);
        chk("R5", "last match address", node_addr, 3);
        chk("R6", "n", n_width, 3);
        chk("R6", "vir length", vir_last_cnt, 8);
        chk("R6", "vir value", vir_last, 64'h68);
        chk("R4", "nibble scans", nib_total, 40);
    endtask

    task automatic t_too_wide();
        words[0] = hub_w(8'd4, 8'd62);
        words[1] = node_w(8'h00); words[2] = node_w(8'h08);
        words[3] = node_w(8'h00); words[4] = node_w(8'h00);
        run(8'd0);
        chk("R8", "error on 65 bits", run_err, 1);
        chk("R8", "no later ir load", ir_n, 2);
        chk("R8", "no vir write", vir_n, 1);
    endtask

    task automatic t_exact_limit();
        words[0] = hub_w(8'd4, 8'd61);
        words[1] = node_w(8'h00); words[2] = node_w(8'h08);
        words[3] = node_w(8'h00); words[4] = node_w(8'h00);
        run(8'd0);
        chk("R8", "64 bits accepted", run_err, 0);
        chk("R8", "vir length", vir_last_cnt, 64);
        chk("R8", "vir value", vir_last, 64'h4000_0000_0000_0008);
        chk("R10", "pin changes while tck high", viol, 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) words[i] = '0;
        mdl_clr = 1'b1; #1; mdl_clr = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_basic();
        t_no_match();
        t_zero_nodes();
        t_single();
        t_duplicate();
        t_too_wide();
        t_exact_limit();
        finish_run();
    end
endmodule